// File: doc/BRIEF.md
# Dual-Mode Filter Control Front End

This block produces the digital control codes for a two-channel programmable filter. A mode-select input chooses where those codes come from. In direct mode, dedicated gain and bandwidth pins drive them. In serial mode, they come from an 8-bit control register that a host loads over a four-wire SPI-style link: chip select, serial clock, serial data in and serial data out. One gain code serves both channels.

The whole block runs on a fast system clock. All external inputs pass through synchronizers, and the serial clock and chip select are edge-detected in that clock domain, so the serial clock must be several system cycles per phase.

While chip select is low, each rising serial clock edge shifts one bit in, most significant bit first. The serial output follows the top shift bit on each falling edge. The rising edge of chip select moves the whole shift register into the control register at once. The serial output is always driven in serial mode, so several of these blocks can be daisy chained on a shared clock and chip select and updated together.

A shared gain pin is an input in direct mode. In serial mode it becomes an output that carries register bit 0, represented here by a separate output value and output-enable pair.

Top module: `ctl_front`

## Requirements
- R1: After reset the control register is zero. In serial mode, gain code is 00 (0 dB), bandwidth select is 0 (lowest), shutdown is 0, the shared-pin output value is 0 and the serial output is 0.
- R2: With the mode input high, the gain code equals {gain1 pin, gain0 pin}, and the bandwidth select is derived from {bw1 pin, bw0 pin}. With the mode input low, both come from the control register.
- R3: In serial mode, while chip select is low, each rising serial clock edge shifts serial data in, MSB first. A chip-select rise copies all 8 bits into the control register. The register layout is bit 7 = gain bit 0, bit 6 = gain bit 1, bit 5 = bandwidth bit 0, bit 4 = bandwidth bit 1, bit 1 = shutdown and bit 0 = general output.
- R4: Decoded outputs do not change while a word is being shifted in. They change only after the chip-select rise.
- R5: Serial clock edges while chip select is high neither shift the register nor change the serial output.
- R6: On each falling serial clock edge while chip select is low, the serial output takes the current top shift-register bit. It keeps that value after chip select rises.
- R7: The gain output in dB is 0, 6, 12 or 24 for gain codes 00, 01, 10 and 11.
- R8: Bandwidth select is 0 (low) for code 00, 1 (middle) for code 01, and 2 (high) for both 10 and 11.
- R9: Register bits 3 and 2 shift through like other bits but change no decoded output.
- R10: With the serial output of block A fed to the serial input of block B, a 16-bit transfer leaves the first 8 bits in B and the last 8 bits in A after one chip-select rise.
- R11: The shared-pin output enable is 1 in serial mode and 0 in direct mode. In serial mode the output value equals register bit 0, and in direct mode it is 0.
- R12: Shutdown is asserted only in serial mode with register bit 1 set. The register keeps its value across a stay in direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin_i | input | 1 | 1 = direct pin control, 0 = serial control |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| pin_gain_i | input | 2 | Direct-mode gain pins {gain1, gain0} |
| pin_bw_i | input | 2 | Direct-mode bandwidth pins {bw1, bw0} |
| sdo_o | output | 1 | Serial data out, always driven |
| gain_code_o | output | 2 | Gain code {gain1, gain0} to both channels |
| gain_db_o | output | 5 | Passband gain in dB |
| bw_sel_o | output | 2 | Bandwidth select, 0 low, 1 middle, 2 high |
| shdn_o | output | 1 | Low-power shutdown request |
| gp_oe_o | output | 1 | Output enable for the shared gain pin |
| gp_out_o | output | 1 | Value driven on the shared gain pin |

## Verification
If the shift register is corrupted, the fault reaches the serial output on the next falling serial clock edge. It also shows in block B of a chain one byte later, and in every decoded output at the next chip-select rise.

If the control register is corrupted, gain, bandwidth, shutdown and shared-pin values differ within four system cycles. Those outputs are checked after every word and after every mode change.

A missing chip-select gate or a wrong edge choice shows up as stale or shifted words at the next commit. The cases where serial clock edges arrive with chip select high, and where a word is half shifted, expose exactly that.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int REG_W  = 8;
  localparam int DB_W   = 5;
  localparam int B_G0   = 7;
  localparam int B_G1   = 6;
  localparam int B_BW0  = 5;
  localparam int B_BW1  = 4;
  localparam int B_SHDN = 1;
  localparam int B_GPO  = 0;

  typedef enum logic [1:0] {BW_LOW = 2'd0, BW_MID = 2'd1, BW_HIGH = 2'd2} bw_sel_e;

  function automatic bw_sel_e bw_norm(input logic [1:0] code);
    if (code[1]) return BW_HIGH;
    else if (code[0]) return BW_MID;
    else return BW_LOW;
  endfunction

  function automatic logic [DB_W-1:0] gain_to_db(input logic [1:0] code);
    case (code)
      2'b00:   return DB_W'(0);
      2'b01:   return DB_W'(6);
      2'b10:   return DB_W'(12);
      default: return DB_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         serial_en,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic [W-1:0] sreg_o,
  output logic         sdo_o,
  output logic         commit_o
);
  logic sclk_d, cs_d;
  logic sclk_rise, sclk_fall, cs_rise, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
    end
  end

  assign sclk_rise = sclk & ~sclk_d;
  assign sclk_fall = ~sclk & sclk_d;
  assign cs_rise   = cs_n & ~cs_d;
  assign active    = serial_en & ~cs_n;
  assign commit_o  = serial_en & cs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_o <= '0;
      sdo_o  <= 1'b0;
    end else begin
      if (active && sclk_rise) sreg_o <= {sreg_o[W-2:0], sdi};
      if (active && sclk_fall) sdo_o  <= sreg_o[W-1];
    end
  end

  // R5: with chip select high the shift register is frozen
  p_frozen_cs_high_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_n && cs_d) |=> $stable(sreg_o));

  // R6: serial output moves only after a falling serial clock edge
  p_sdo_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !(active && sclk_fall) |=> $stable(sdo_o));

  // R3: a shift enters the serial bit at the bottom
  p_shift_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    (active && sclk_rise) |=> (sreg_o[0] == $past(sdi)));
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            serial_en,
  input  logic            commit,
  input  logic [W-1:0]    sreg,
  input  logic [1:0]      pin_gain,
  input  logic [1:0]      pin_bw,
  output logic [1:0]      gain_code_o,
  output logic [DB_W-1:0] gain_db_o,
  output logic [1:0]      bw_sel_o,
  output logic            shdn_o,
  output logic            gp_oe_o,
  output logic            gp_out_o
);
  logic [W-1:0] ctl_q;
  logic [1:0]   gain_sel, bw_raw;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (commit) ctl_q <= sreg;
  end

  always_comb begin
    if (serial_en) begin
      gain_sel = {ctl_q[B_G1], ctl_q[B_G0]};
      bw_raw   = {ctl_q[B_BW1], ctl_q[B_BW0]};
    end else begin
      gain_sel = pin_gain;
      bw_raw   = pin_bw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_code_o <= '0;
      gain_db_o   <= '0;
      bw_sel_o    <= BW_LOW;
      shdn_o      <= 1'b0;
      gp_oe_o     <= 1'b1;
      gp_out_o    <= 1'b0;
    end else begin
      gain_code_o <= gain_sel;
      gain_db_o   <= gain_to_db(gain_sel);
      bw_sel_o    <= bw_norm(bw_raw);
      shdn_o      <= serial_en & ctl_q[B_SHDN];
      gp_oe_o     <= serial_en;
      gp_out_o    <= serial_en & ctl_q[B_GPO];
    end
  end

  // R4: the control register changes only on a commit
  p_reg_on_commit_r4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(ctl_q));

  // R8: the select never takes the unused value 3
  p_bw_legal_r8: assert property (@(posedge clk) disable iff (rst)
    bw_sel_o != 2'b11);

  // R7: gain in dB is one of four legal steps
  p_db_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (gain_db_o == 5'd0) || (gain_db_o == 5'd6) || (gain_db_o == 5'd12) || (gain_db_o == 5'd24));
endmodule

// File: rtl/ctl_front.sv
module ctl_front
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_pin_i,
  input  logic            cs_n_i,
  input  logic            sclk_i,
  input  logic            sdi_i,
  input  logic [1:0]      pin_gain_i,
  input  logic [1:0]      pin_bw_i,
  output logic            sdo_o,
  output logic [1:0]      gain_code_o,
  output logic [DB_W-1:0] gain_db_o,
  output logic [1:0]      bw_sel_o,
  output logic            shdn_o,
  output logic            gp_oe_o,
  output logic            gp_out_o
);
  localparam int IN_W = 8;
  localparam logic [IN_W-1:0] IN_RST = 8'b0100_0000;

  logic [IN_W-1:0] raw_in, syn_in;
  logic            mode_s, cs_s, sclk_s, sdi_s, serial_en, commit;
  logic [1:0]      pg_s, pb_s;
  logic [REG_W-1:0] sreg;

  assign raw_in = {mode_pin_i, cs_n_i, sclk_i, sdi_i, pin_gain_i, pin_bw_i};

  ctl_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in));

  assign {mode_s, cs_s, sclk_s, sdi_s, pg_s, pb_s} = syn_in;
  assign serial_en = ~mode_s;

  ctl_shifter #(.W(REG_W)) u_shift (
    .clk(clk), .rst(rst), .serial_en(serial_en), .cs_n(cs_s), .sclk(sclk_s),
    .sdi(sdi_s), .sreg_o(sreg), .sdo_o(sdo_o), .commit_o(commit));

  ctl_decode #(.W(REG_W)) u_dec (
    .clk(clk), .rst(rst), .serial_en(serial_en), .commit(commit), .sreg(sreg),
    .pin_gain(pg_s), .pin_bw(pb_s), .gain_code_o(gain_code_o), .gain_db_o(gain_db_o),
    .bw_sel_o(bw_sel_o), .shdn_o(shdn_o), .gp_oe_o(gp_oe_o), .gp_out_o(gp_out_o));

  // R12: shutdown never asserted while the shared pin is an input
  p_shdn_serial_only_r12: assert property (@(posedge clk) disable iff (rst)
    !gp_oe_o |-> !shdn_o);

  // R11: shared pin value is low whenever its driver is off
  p_gp_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !gp_oe_o |-> !gp_out_o);
endmodule

// File: tb/tb_ctl_front.sv
module tb_ctl_front;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic mode_pin = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [1:0] pg = 2'b00, pb = 2'b00;

  logic a_sdo, a_shdn, a_oe, a_out, b_sdo, b_shdn, b_oe, b_out;
  logic [1:0] a_gc, a_bw, b_gc, b_bw;
  logic [4:0] a_db, b_db;

  ctl_front dut (.clk(clk), .rst(rst), .mode_pin_i(mode_pin), .cs_n_i(cs_n), .sclk_i(sclk),
    .sdi_i(sdi), .pin_gain_i(pg), .pin_bw_i(pb), .sdo_o(a_sdo), .gain_code_o(a_gc),
    .gain_db_o(a_db), .bw_sel_o(a_bw), .shdn_o(a_shdn), .gp_oe_o(a_oe), .gp_out_o(a_out));

  ctl_front dut_b (.clk(clk), .rst(rst), .mode_pin_i(mode_pin), .cs_n_i(cs_n), .sclk_i(sclk),
    .sdi_i(a_sdo), .pin_gain_i(pg), .pin_bw_i(pb), .sdo_o(b_sdo), .gain_code_o(b_gc),
    .gain_db_o(b_db), .bw_sel_o(b_bw), .shdn_o(b_shdn), .gp_oe_o(b_oe), .gp_out_o(b_out));

  int checks = 0, errors = 0;
  logic [7:0] m_sreg = '0, m_sreg_b = '0, m_lat = '0, m_lat_b = '0;
  logic m_sdo = 1'b0, m_sdo_b = 1'b0;

  function automatic logic [4:0] exp_db(input logic [1:0] c);
    case (c)
      2'b00: return 5'd0;
      2'b01: return 5'd6;
      2'b10: return 5'd12;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [1:0] exp_bw(input logic [1:0] c);
    return c[1] ? 2'd2 : (c[0] ? 2'd1 : 2'd0);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0; wait_clk(H);
  endtask

  task automatic cs_high();
    cs_n = 1'b1; m_lat = m_sreg; m_lat_b = m_sreg_b; wait_clk(H);
  endtask

  task automatic bit_clk(input logic b);
    sdi = b; wait_clk(H);
    sclk = 1'b1;
    m_sreg_b = {m_sreg_b[6:0], m_sdo};
    m_sreg = {m_sreg[6:0], b};
    wait_clk(H);
    sclk = 1'b0;
    m_sdo = m_sreg[7];
    m_sdo_b = m_sreg_b[7];
    wait_clk(H);
  endtask

  task automatic write_word(input logic [7:0] v);
    cs_low();
    for (int i = 7; i >= 0; i--) bit_clk(v[i]);
    cs_high();
  endtask

  task automatic check_a(input string tag);
    chk({tag, " gain code"}, 16'(a_gc), 16'({m_lat[6], m_lat[7]}));
    chk({tag, " R7 gain db"}, 16'(a_db), 16'(exp_db({m_lat[6], m_lat[7]})));
    chk({tag, " R8 bw"}, 16'(a_bw), 16'(exp_bw({m_lat[4], m_lat[5]})));
    chk({tag, " R12 shdn"}, 16'(a_shdn), 16'(m_lat[1]));
    chk({tag, " R11 oe"}, 16'(a_oe), 16'd1);
    chk({tag, " R11 out"}, 16'(a_out), 16'(m_lat[0]));
    chk({tag, " R6 sdo"}, 16'(a_sdo), 16'(m_sdo));
  endtask

  task automatic check_b(input string tag);
    chk({tag, " B gain"}, 16'(b_gc), 16'({m_lat_b[6], m_lat_b[7]}));
    chk({tag, " B bw"}, 16'(b_bw), 16'(exp_bw({m_lat_b[4], m_lat_b[5]})));
    chk({tag, " B shdn/out"}, 16'({b_shdn, b_out}), 16'({m_lat_b[1], m_lat_b[0]}));
    chk({tag, " B sdo"}, 16'(b_sdo), 16'(m_sdo_b));
  endtask

  task automatic check_pin(input string tag);
    chk({tag, " R2 gain"}, 16'(a_gc), 16'(pg));
    chk({tag, " R7 db"}, 16'(a_db), 16'(exp_db(pg)));
    chk({tag, " R8 bw"}, 16'(a_bw), 16'(exp_bw(pb)));
    chk({tag, " R12 shdn"}, 16'(a_shdn), 16'd0);
    chk({tag, " R11 oe/out"}, 16'({a_oe, a_out}), 16'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] save;
    logic [15:0] pair;
    void'($urandom(32'd2718));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(H);
    check_a("R1 reset");
    chk("R1 db zero", 16'(a_db), 16'd0);

    write_word(8'b1000_0000); check_a("R3 R7 gain01");
    chk("R7 6dB", 16'(a_db), 16'd6);
    write_word(8'b0100_0000); check_a("R3 R7 gain10");
    write_word(8'b1100_0000); check_a("R3 R7 gain11");
    chk("R7 24dB", 16'(a_db), 16'd24);
    write_word(8'b0010_0000); check_a("R8 mid");
    chk("R8 mid value", 16'(a_bw), 16'd1);
    write_word(8'b0001_0000); check_a("R8 code10");
    write_word(8'b0011_0000); check_a("R8 code11");
    chk("R8 11 high", 16'(a_bw), 16'd2);
    write_word(8'b0000_0010); check_a("R3 shdn bit");
    write_word(8'b0000_0001); check_a("R11 gpo bit");
    chk("R11 out high", 16'(a_out), 16'd1);

    // R4: half a word shifted, outputs keep the old register
    write_word(8'b1100_0011);
    cs_low();
    for (int i = 0; i < 4; i++) bit_clk(1'b0);
    check_a("R4 mid word");
    for (int i = 0; i < 4; i++) bit_clk(1'b1);
    cs_high();
    check_a("R4 after commit");

    // R5: clock edges with chip select high are ignored
    write_word(8'b1011_0010);
    save = m_lat;
    for (int i = 0; i < 3; i++) begin
      sdi = ~sdi; wait_clk(H); sclk = 1'b1; wait_clk(H); sclk = 1'b0; wait_clk(H);
    end
    chk("R5 sdo held", 16'(a_sdo), 16'(m_sdo));
    cs_low(); cs_high();
    chk("R5 model", 16'(m_lat), 16'(save));
    check_a("R5 recommit");

    // R9: bits 3 and 2 have no decoded effect but pass through
    write_word(8'b1010_1100);
    pair = {a_gc, a_bw, a_db, a_shdn, a_out, 4'b0};
    check_a("R9 with");
    write_word(8'b1010_0000);
    chk("R9 same outputs", {a_gc, a_bw, a_db, a_shdn, a_out, 4'b0}, pair);
    check_b("R9 chained");

    // R10: 16-bit chained transfer
    cs_low();
    for (int i = 15; i >= 0; i--) bit_clk(i >= 8 ? 1'(16'h40A3 >> i) : 1'(16'h40A3 >> i));
    cs_high();
    chk("R10 B gets first byte", 16'({b_gc, b_shdn, b_out}), 16'({2'b10, 1'b0, 1'b0}));
    chk("R10 A gets last byte", 16'({a_gc, a_shdn, a_out}), 16'({2'b01, 1'b1, 1'b1}));
    check_a("R10 A");
    check_b("R10 B");

    // R2 / R12: direct mode, then back to serial
    write_word(8'b1101_0011);
    mode_pin = 1'b1; pg = 2'b10; pb = 2'b01; wait_clk(H);
    check_pin("R2 pin a");
    pg = 2'b11; pb = 2'b11; wait_clk(H);
    check_pin("R2 pin b");
    mode_pin = 1'b0; wait_clk(H);
    check_a("R12 restored");
    chk("R12 shdn back", 16'(a_shdn), 16'd1);

    for (int n = 0; n < 40; n++) begin
      write_word(8'($urandom));
      check_a("R3 random");
      check_b("R10 random");
      if (n % 8 == 3) begin
        mode_pin = 1'b1; pg = 2'($urandom); pb = 2'($urandom); wait_clk(H);
        check_pin("R2 random pin");
        mode_pin = 1'b0; wait_clk(H);
        check_a("R12 random back");
      end
    end

    summary();
    $finish;
  end
endmodule